// File: doc/BRIEF.md
# SPI Register Access Engine

This block is a serial slave that gives an external SPI master access to a small sensor register file. The master clocks fixed 16-bit frames in mode 0: the idle clock is low, the master changes data on the falling edge and samples on the rising edge. The first byte from the master holds a 6-bit register address, one access-type bit and a padding zero. The second byte holds write data. On reads, the register value comes back on MISO during the second byte. While the first byte is being received, MISO carries a fixed status header that includes a power-on-reset flag.

The serial pins are oversampled by a faster system clock through two-flop synchronisers, and all edge detection runs on the synchronised clock. Toward the register file the block offers a plain register bus: an address, a one-cycle write strobe, write data, and combinational read data.

A read of one of the six angular-rate output registers can continue past the second byte while chip select stays low. Each further byte comes from the next lower address, and the address steps from 0Ch back up to 11h. The bench stands in for the register file.

Top module: `spi_regport`

## Requirements
- R1: Frame bits arrive MSB first on MOSI and are sampled on SCK rising edges. Bits 1–6 are the register address (A5 first), bit 7 is the access type (0 = read, 1 = write), bit 8 is a pad bit that is ignored, and bits 9–16 are the write data.
- R2: During bits 1–8, MISO carries a header. Bit 1 is unspecified. Bit 2 is 0. Bits 3, 4 and 5 each equal the power-on-reset flag input. Bit 6 is 0, bit 7 is 1 and bit 8 is 0. A new MISO bit is presented after each SCK falling edge.
- R3: On a read frame, the register at the received address is captured after the 8th rising SCK edge and appears on MISO in bits 9–16, MSB first.
- R4: On a write frame, MISO is 0 in bit 9 and in every later bit of the frame.
- R5: A write frame of at least 16 bits produces exactly one write strobe, after the 16th SCK falling edge, carrying the received address and data. Further bits in the same frame produce no more strobes.
- R6: A frame whose chip select rises before the 16th SCK falling edge produces no write strobe.
- R7: MISO output enable is low while chip select is high and high during a frame.
- R8: A read whose address lies in 0Ch–11h continues for as long as the master keeps clocking. Each extra byte returns the register one address lower, and 0Ch is followed by 11h.
- R9: A read whose address lies outside 0Ch–11h returns only one data byte. Every later bit of that frame is 0.
- R10: A falling edge of chip select restarts bit counting, so a complete frame that follows an aborted one is decoded correctly.
- R11: A read frame never produces a write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than SCK |
| rst | input | 1 | Synchronous active-high reset |
| sck_i | input | 1 | Serial clock from the master |
| mosi_i | input | 1 | Serial data from the master |
| csb_i | input | 1 | Chip select, active low |
| miso_o | output | 1 | Serial data to the master |
| miso_oe_o | output | 1 | MISO drive enable; low means high impedance |
| por_flag_i | input | 1 | Power-on-reset status bit copied into the header |
| reg_addr_o | output | 6 | Register file address |
| reg_wr_o | output | 1 | One-cycle write strobe |
| reg_wdata_o | output | 8 | Write data |
| reg_rdata_i | input | 8 | Read data for reg_addr_o, combinational |

## Verification
A bit counter out of step with the SCK edges shows within the same frame. The header bits shift one position on MISO, the read byte comes back rotated, and the write strobe moves off the 16th falling edge or vanishes. A wrong burst address step shows on the very next data byte, where the register of the wrong address appears. Stale state left over from an aborted frame shows in the header or the address of the next full frame.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;

    localparam int ADDR_W = 6;
    localparam int DATA_W = 8;
    localparam int BIT_W  = $clog2(DATA_W);

    localparam logic [ADDR_W-1:0] BURST_LO = 6'h0C;
    localparam logic [ADDR_W-1:0] BURST_HI = 6'h11;

    typedef enum logic {
        ACC_READ  = 1'b0,
        ACC_WRITE = 1'b1
    } acc_e;

    // First byte of a frame without its pad bit
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        acc_e              acc;
    } cmd_t;

    // Which byte of the frame is being received; saturates at DATA_EXTRA
    typedef enum logic [1:0] {
        BYTE_CMD   = 2'd0,
        BYTE_DATA  = 2'd1,
        BYTE_EXTRA = 2'd2
    } byte_e;

    function automatic logic in_burst(input logic [ADDR_W-1:0] a);
        return (a >= BURST_LO) && (a <= BURST_HI);
    endfunction

    function automatic logic [ADDR_W-1:0] burst_next(input logic [ADDR_W-1:0] a);
        return (a == BURST_LO) ? BURST_HI : a - 6'd1;
    endfunction

    function automatic logic [DATA_W-1:0] status_header(input logic por);
        return {1'b0, 1'b0, por, por, por, 1'b0, 1'b1, 1'b0};
    endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int          W       = 3,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] stg [STAGES];
    logic [W-1:0] prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
            prev <= RST_VAL;
        end else begin
            stg[0] <= din;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
            prev <= stg[STAGES-1];
        end
    end

    assign dout = stg[STAGES-1];

    for (genvar b = 0; b < W; b++) begin : g_edge
        assign rise[b] =  stg[STAGES-1][b] & ~prev[b];
        assign fall[b] = ~stg[STAGES-1][b] &  prev[b];
    end
endmodule

// File: rtl/spi_frame_rx.sv
module spi_frame_rx
    import spi_regport_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic              frame_start,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              mosi,
    output cmd_t              cmd,
    output logic [DATA_W-1:0] wdata,
    output logic              wr_stb,
    output logic              load_req,
    output logic              load_zero,
    output logic              tx_shift,
    output byte_e             byte_idx
);
    logic [BIT_W-1:0]  bit_q;
    logic [DATA_W-1:0] rx_q;
    logic [DATA_W-1:0] rx_n;
    logic              wr_done;

    assign rx_n     = {rx_q[DATA_W-2:0], mosi};
    assign tx_shift = active & sck_fall & (bit_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_q     <= '0;
            byte_idx  <= BYTE_CMD;
            rx_q      <= '0;
            cmd       <= '{addr: '0, acc: ACC_READ};
            wdata     <= '0;
            wr_stb    <= 1'b0;
            wr_done   <= 1'b0;
            load_req  <= 1'b0;
            load_zero <= 1'b0;
        end else begin
            wr_stb   <= 1'b0;
            load_req <= 1'b0;
            if (frame_start) begin
                bit_q    <= '0;
                byte_idx <= BYTE_CMD;
                wr_done  <= 1'b0;
            end else if (active && sck_rise) begin
                rx_q  <= rx_n;
                bit_q <= bit_q + 1'b1;
                if (bit_q == BIT_W'(DATA_W-1)) begin
                    load_req <= 1'b1;
                    if (byte_idx != BYTE_EXTRA) byte_idx <= byte_e'(byte_idx + 2'd1);
                    if (byte_idx == BYTE_CMD) begin
                        cmd       <= cmd_t'(rx_n[DATA_W-1:1]);
                        load_zero <= rx_n[1];
                    end else begin
                        if (byte_idx == BYTE_DATA) wdata <= rx_n;
                        if (cmd.acc == ACC_READ && in_burst(cmd.addr)) begin
                            cmd.addr  <= burst_next(cmd.addr);
                            load_zero <= 1'b0;
                        end else begin
                            load_zero <= 1'b1;
                        end
                    end
                end
            end else if (active && sck_fall && byte_idx == BYTE_EXTRA &&
                         bit_q == '0 && cmd.acc == ACC_WRITE && !wr_done) begin
                wr_stb  <= 1'b1;
                wr_done <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/spi_tx_shift.sv
module spi_tx_shift
    import spi_regport_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start,
    input  logic              por,
    input  logic              load_req,
    input  logic              load_zero,
    input  logic [DATA_W-1:0] rdata,
    input  logic              shift,
    output logic              sdo
);
    logic [DATA_W-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst)              sh_q <= '0;
        else if (frame_start) sh_q <= status_header(por);
        else if (load_req)    sh_q <= load_zero ? '0 : rdata;
        else if (shift)       sh_q <= {sh_q[DATA_W-2:0], 1'b0};
    end

    assign sdo = sh_q[DATA_W-1];
endmodule

// File: rtl/spi_regport.sv
module spi_regport
    import spi_regport_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sck_i,
    input  logic              mosi_i,
    input  logic              csb_i,
    output logic              miso_o,
    output logic              miso_oe_o,
    input  logic              por_flag_i,
    output logic [ADDR_W-1:0] reg_addr_o,
    output logic              reg_wr_o,
    output logic [DATA_W-1:0] reg_wdata_o,
    input  logic [DATA_W-1:0] reg_rdata_i
);
    localparam int PINS = 3;  // {csb, mosi, sck}

    logic [PINS-1:0] pin_s, pin_rise, pin_fall;
    logic            active, frame_start;
    cmd_t            cmd;
    byte_e           frame_byte;
    logic            frame_write;
    logic            load_req, load_zero, tx_shift, sdo;

    spi_pin_sync #(
        .W      (PINS),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b100)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .din ({csb_i, mosi_i, sck_i}),
        .dout(pin_s),
        .rise(pin_rise),
        .fall(pin_fall)
    );

    assign active      = ~pin_s[2];
    assign frame_start = pin_fall[2];

    spi_frame_rx u_rx (
        .clk        (clk),
        .rst        (rst),
        .active     (active),
        .frame_start(frame_start),
        .sck_rise   (pin_rise[0]),
        .sck_fall   (pin_fall[0]),
        .mosi       (pin_s[1]),
        .cmd        (cmd),
        .wdata      (reg_wdata_o),
        .wr_stb     (reg_wr_o),
        .load_req   (load_req),
        .load_zero  (load_zero),
        .tx_shift   (tx_shift),
        .byte_idx   (frame_byte)
    );

    spi_tx_shift u_tx (
        .clk        (clk),
        .rst        (rst),
        .frame_start(frame_start),
        .por        (por_flag_i),
        .load_req   (load_req),
        .load_zero  (load_zero),
        .rdata      (reg_rdata_i),
        .shift      (tx_shift),
        .sdo        (sdo)
    );

    assign frame_write = (cmd.acc == ACC_WRITE);
    assign reg_addr_o  = cmd.addr;
    assign miso_oe_o   = active;
    assign miso_o      = active & sdo;
endmodule

// File: rtl/spi_regport_chk.sv
module spi_regport_chk (
    input logic       clk,
    input logic       rst,
    input logic       csb_i,
    input logic       miso_oe_o,
    input logic       reg_wr_o,
    input logic [5:0] reg_addr_o,
    input logic [1:0] frame_byte,
    input logic       frame_write
);
    // R5: a write strobe lasts one cycle
    p_wr_single_r5: assert property (@(posedge clk) disable iff (rst)
        reg_wr_o |=> !reg_wr_o);

    // R5: the strobe only comes once both bytes are in
    p_wr_after_data_r5: assert property (@(posedge clk) disable iff (rst)
        reg_wr_o |-> frame_byte == 2'd2);

    // R6: a strobe needs a frame that was open on the previous cycle
    p_wr_in_frame_r6: assert property (@(posedge clk) disable iff (rst)
        reg_wr_o |-> $past(miso_oe_o));

    // R11: never a strobe for a read frame
    p_no_wr_on_read_r11: assert property (@(posedge clk) disable iff (rst)
        reg_wr_o |-> frame_write);

    // R7: chip select high for three cycles turns the driver off
    p_oe_off_r7: assert property (@(posedge clk) disable iff (rst)
        (csb_i && $past(csb_i) && $past(csb_i, 2)) |-> !miso_oe_o);

    // R8: an address change after the command byte is a burst step
    p_burst_step_r8: assert property (@(posedge clk) disable iff (rst)
        (!$stable(reg_addr_o) && $past(frame_byte) != 2'd0) |->
        (reg_addr_o == (($past(reg_addr_o) == 6'h0C) ? 6'h11 : $past(reg_addr_o) - 6'd1)));
endmodule

bind spi_regport spi_regport_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .csb_i      (csb_i),
    .miso_oe_o  (miso_oe_o),
    .reg_wr_o   (reg_wr_o),
    .reg_addr_o (reg_addr_o),
    .frame_byte (frame_byte),
    .frame_write(frame_write)
);

// File: tb/spi_regport_bench.sv
`timescale 1ns/1ps
module spi_regport_bench;
    localparam int HALF  = 8;       // system clocks per SCK half period
    localparam int LIMIT = 150000;  // watchdog in clock cycles

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sck = 1'b0, mosi = 1'b0, csb = 1'b1, por = 1'b0;
    logic       miso, miso_oe, reg_wr;
    logic [5:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;

    logic [7:0] regs     [64];
    logic [7:0] exp_regs [64];
    int         wr_count = 0;
    int         n_checks = 0, n_fail = 0, cycles = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    spi_regport u_spi_regport (
        .clk(clk), .rst(rst), .sck_i(sck), .mosi_i(mosi), .csb_i(csb),
        .miso_o(miso), .miso_oe_o(miso_oe), .por_flag_i(por),
        .reg_addr_o(reg_addr), .reg_wr_o(reg_wr), .reg_wdata_o(reg_wdata),
        .reg_rdata_i(reg_rdata)
    );

    assign reg_rdata = regs[reg_addr];

    always @(posedge clk) begin
        if (reg_wr) begin
            regs[reg_addr] <= reg_wdata;
            wr_count <= wr_count + 1;
        end
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == LIMIT && !done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: run hung, actual %0d cycles, expected < %0d", cycles, LIMIT);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
        end
    endtask

    function automatic bit b_inrange(input logic [5:0] a);
        return a >= 6'd12 && a <= 6'd17;
    endfunction

    function automatic logic [5:0] b_step(input logic [5:0] a);
        return (a == 6'd12) ? 6'd17 : a - 6'd1;
    endfunction

    // Expected MISO byte k (k >= 1) of a frame
    function automatic logic [7:0] exp_byte(input logic [5:0] a, input bit wr, input int k);
        logic [5:0] p = a;
        if (wr) return 8'h00;
        if (k == 1) return exp_regs[a];
        if (!b_inrange(a)) return 8'h00;
        for (int j = 1; j < k; j++) p = b_step(p);
        return exp_regs[p];
    endfunction

    task automatic frame(input logic [5:0] a, input bit wr, input logic [7:0] wd,
                         input int nbits, input bit p, input string tag);
        logic [7:0] got [8];
        bit         oe_ok = 1'b1;
        int         wc0 = wr_count;
        logic [15:0] cmdv = {a, wr, 1'b0, wd};
        for (int k = 0; k < 8; k++) got[k] = 8'h00;
        @(negedge clk);
        por = p; csb = 1'b0; mosi = cmdv[15];
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            got[i/8][7 - (i%8)] = miso;
            if (!miso_oe) oe_ok = 1'b0;
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
            mosi = (i + 1 < 16) ? cmdv[14 - i] : 1'b0;
            repeat (HALF) @(negedge clk);
        end
        csb = 1'b1;
        repeat (4 * HALF) @(negedge clk);
        check(oe_ok, {"R7 oe during frame ", tag}, oe_ok, 1);
        check(miso_oe == 1'b0, {"R7 oe idle ", tag}, miso_oe, 0);
        if (nbits >= 8)
            check(got[0][6:0] == {1'b0, p, p, p, 1'b0, 1'b1, 1'b0}, {"R2 header ", tag},
                  got[0][6:0], {1'b0, p, p, p, 1'b0, 1'b1, 1'b0});
        for (int k = 1; k < nbits / 8; k++) begin
            string rq;
            rq = wr ? "R4" : (k == 1 ? "R1/R3" : (b_inrange(a) ? "R8" : "R9"));
            check(got[k] == exp_byte(a, wr, k), {rq, " data byte ", tag}, got[k], exp_byte(a, wr, k));
        end
        if (wr && nbits >= 16) begin
            exp_regs[a] = wd;
            check(wr_count == wc0 + 1, {"R5 one strobe ", tag}, wr_count - wc0, 1);
            check(regs[a] == wd, {"R5/R1 written value ", tag}, regs[a], wd);
        end else begin
            check(wr_count == wc0, {wr ? "R6 no strobe on abort " : "R11 no strobe on read ", tag},
                  wr_count - wc0, 0);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 64; i++) begin
            regs[i]     = 8'((i * 37 + 5) & 8'hFF);
            exp_regs[i] = 8'((i * 37 + 5) & 8'hFF);
        end
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check(miso_oe == 1'b0, "R7 reset oe", miso_oe, 0);
        check(reg_wr == 1'b0, "R5 reset strobe", reg_wr, 0);

        // directed corner cases
        frame(6'h02, 1'b1, 8'hA5, 16, 1'b1, "write 02");
        frame(6'h02, 1'b0, 8'hFF, 16, 1'b0, "read 02");            // R1, R3
        frame(6'h0E, 1'b0, 8'h00, 40, 1'b1, "burst 0E");           // R8
        frame(6'h0C, 1'b0, 8'h00, 32, 1'b0, "burst wrap 0C");      // R8 wrap
        frame(6'h11, 1'b0, 8'h00, 64, 1'b1, "burst full ring");    // R8
        frame(6'h20, 1'b0, 8'h00, 32, 1'b0, "single read 20");     // R9
        frame(6'h0B, 1'b0, 8'h00, 24, 1'b1, "below range 0B");     // R9
        frame(6'h05, 1'b1, 8'h3C, 12, 1'b0, "abort at 12");        // R6
        frame(6'h05, 1'b1, 8'h3C, 15, 1'b0, "abort at 15");        // R6
        frame(6'h05, 1'b1, 8'hC3, 16, 1'b1, "R10 after abort");    // R10
        frame(6'h0D, 1'b1, 8'h5A, 32, 1'b0, "long write");         // R4, R5
        frame(6'h05, 1'b0, 8'h00, 16, 1'b0, "R10 readback");

        // constrained random
        for (int n = 0; n < 40; n++) begin
            logic [5:0] a;
            bit         w;
            int         nb;
            a  = ($urandom % 2) ? 6'(12 + $urandom % 6) : 6'($urandom % 64);
            w  = ($urandom % 3) == 0;
            nb = 8 * (2 + $urandom % 3);
            if (($urandom % 8) == 0) nb = 9 + $urandom % 7;
            frame(a, w, 8'($urandom), nb, 1'($urandom), "random");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule